// File: doc/BRIEF.md
# Control IN Endpoint Zero Register and Handshake Selector

This block keeps the control word that software programs for the default control IN endpoint of a USB device. Through a simple register port it accepts 32-bit writes and presents the current word as a combinational read. The protocol engine sends single-cycle events into it: a SETUP packet arrived, the transfer finished, or the endpoint was disabled. The block reacts to these by clearing or setting its own bits.

From the stored state and two chip-wide NAK inputs, the block works out which handshake the endpoint returns to an IN token: send data, NAK or STALL. After the core clears the enable bit it raises a one-cycle pulse for transfer-complete and one for endpoint-disabled, which an external interrupt controller can latch.

The NAK flag is internal and does not appear in the read word. Software moves it through two strobe bits, and the result can be seen only on the handshake output.

Top module: `ep0_ctrl`

## Requirements
- R1: After reset the read word is all zeros, `ep_enabled` and both pulse outputs are 0, and `hs_sel` reads 2'b01 (NAK).
- R2: A write with bit 31 = 1 sets the enable flag. A write with bit 31 = 0 leaves it unchanged. A `xfer_done` or `dis_done` event clears it, and the event wins over a set write in the same cycle. The flag reads back at bit 31 and on `ep_enabled`.
- R3: A write with bit 30 = 1 sets the disable flag only if the enable flag was already 1 before that write. Otherwise the write is ignored. `dis_done` clears the flag, and it reads back at bit 30.
- R4: `done_irq` pulses for exactly the cycle after a `xfer_done` event, and `dis_irq` pulses for exactly the cycle after a `dis_done` event. In that cycle the flags the event cleared already read 0.
- R5: Writing bit 27 = 1 sets the internal NAK flag and writing bit 26 = 1 clears it. If both are written in one cycle, the flag ends up set. Both bits read as 0.
- R6: A `setup_rx` event sets the NAK flag and clears the STALL flag. This overrides a clear-NAK or set-STALL write in the same cycle.
- R7: A write with bit 21 = 1 sets the STALL flag, and it reads back at bit 21. A write with bit 21 = 0 leaves it unchanged.
- R8: `hs_sel` is 2'b10 (STALL) whenever STALL is set, whatever the NAK sources are. Otherwise it is 2'b00 (DATA) only when enable is 1, NAK is 0 and both `gnp_in_nak` and `gout_nak` are 0. In every other case it is 2'b01 (NAK).
- R9: Bits 25:22 read the parameter `FIFO_NUM` (default 0). Bits 19:18 read 2'b00 (control type). Bits 29:28, 20, 17:0, 27 and 26 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register word |
| setup_rx | input | 1 | SETUP packet received on this endpoint |
| xfer_done | input | 1 | Transfer completed event |
| dis_done | input | 1 | Endpoint disable completed event |
| gnp_in_nak | input | 1 | Global non-periodic IN NAK active |
| gout_nak | input | 1 | Global OUT NAK active |
| ep_enabled | output | 1 | Enable flag |
| done_irq | output | 1 | Transfer-complete pulse |
| dis_irq | output | 1 | Endpoint-disabled pulse |
| hs_sel | output | 2 | Handshake choice: 00 DATA, 01 NAK, 10 STALL |

## Verification
The hardest situation to reach is a set-disable write that lands while enable is 1, and in particular one that lands in the same cycle as an event clearing enable. Random writes seldom put bit 31 and bit 30 into the right order. For that reason, directed sequences first enable the endpoint, then write disable, and then fire `dis_done`, including a variant where the set write and the event coincide. Same-cycle collisions of SETUP with clear-NAK and with set-STALL are also forced directly. After that, weighted random traffic mixes everything against a bench model.

// File: rtl/ep0_ctrl.sv
module ep0_ctrl #(
  parameter int         DW       = 32,
  parameter logic [3:0] FIFO_NUM = 4'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          setup_rx,
  input  logic          xfer_done,
  input  logic          dis_done,
  input  logic          gnp_in_nak,
  input  logic          gout_nak,
  output logic          ep_enabled,
  output logic          done_irq,
  output logic          dis_irq,
  output logic [1:0]    hs_sel
);
  localparam int B_EN   = 31;
  localparam int B_DIS  = 30;
  localparam int B_SNAK = 27;
  localparam int B_CNAK = 26;
  localparam int B_FIFO = 22;
  localparam int B_STL  = 21;
  localparam logic [1:0] HS_DATA  = 2'b00;
  localparam logic [1:0] HS_NAK   = 2'b01;
  localparam logic [1:0] HS_STALL = 2'b10;

  logic en_q, dis_q, nak_q, stall_q, done_q, disirq_q;

  wire w_en   = wr_en & wr_data[B_EN];
  wire w_dis  = wr_en & wr_data[B_DIS] & en_q;
  wire w_snak = wr_en & wr_data[B_SNAK];
  wire w_cnak = wr_en & wr_data[B_CNAK];
  wire w_stl  = wr_en & wr_data[B_STL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      dis_q    <= 1'b0;
      nak_q    <= 1'b0;
      stall_q  <= 1'b0;
      done_q   <= 1'b0;
      disirq_q <= 1'b0;
    end else begin
      en_q     <= (xfer_done | dis_done) ? 1'b0 : (en_q | w_en);
      dis_q    <= dis_done ? 1'b0 : (dis_q | w_dis);
      nak_q    <= setup_rx | w_snak | (nak_q & ~w_cnak);
      stall_q  <= setup_rx ? 1'b0 : (stall_q | w_stl);
      done_q   <= xfer_done;
      disirq_q <= dis_done;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[B_EN]  = en_q;
    rd_data[B_DIS] = dis_q;
    rd_data[B_FIFO +: 4] = FIFO_NUM;
    rd_data[B_STL] = stall_q;
  end

  wire any_nak = nak_q | gnp_in_nak | gout_nak | ~en_q;
  assign hs_sel     = stall_q ? HS_STALL : (any_nak ? HS_NAK : HS_DATA);
  assign ep_enabled = en_q;
  assign done_irq   = done_q;
  assign dis_irq    = disirq_q;

  // R3
  dis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_q) |-> $past(en_q));

  // R2
  xfer_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !ep_enabled && done_irq);

  // R4
  dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_done |=> !ep_enabled && !rd_data[B_DIS] && dis_irq);

  // R6
  setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx |=> !rd_data[B_STL] && hs_sel == HS_NAK);

  // R8
  stall_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(w_stl) && !$past(setup_rx)) |-> hs_sel == HS_STALL);
endmodule

// File: tb/tb_ep0_ctrl.sv
`timescale 1ns/1ps
module tb_ep0_ctrl;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic setup_rx = 0, xfer_done = 0, dis_done = 0, gnp_in_nak = 0, gout_nak = 0;
  logic ep_enabled, done_irq, dis_irq;
  logic [1:0] hs_sel;
  int n_run = 0, n_fail = 0;
  bit m_en, m_dis, m_nak, m_stall, m_di, m_ri;

  always #2.5 clk = ~clk;

  ep0_ctrl dut (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .setup_rx, .xfer_done,
    .dis_done, .gnp_in_nak, .gout_nak, .ep_enabled, .done_irq, .dis_irq, .hs_sel);

  function automatic logic [1:0] exp_hs(bit en, bit nak, bit st, bit gi, bit go);
    if (st) return 2'b10;
    if (en && !nak && !gi && !go) return 2'b00;
    return 2'b01;
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    r[31] = m_en; r[30] = m_dis; r[21] = m_stall;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit we, logic [31:0] wd, bit su, bit xd, bit dd, bit gi, bit go);
    bit n_en, n_dis, n_nak, n_st;
    wr_en = we; wr_data = wd; setup_rx = su; xfer_done = xd; dis_done = dd;
    gnp_in_nak = gi; gout_nak = go;
    #1;
    chk("R8 hs", {30'b0, hs_sel}, {30'b0, exp_hs(m_en, m_nak, m_stall, gi, go)});
    n_en = m_en;  if (we && wd[31]) n_en = 1; if (xd || dd) n_en = 0;
    n_dis = m_dis; if (we && wd[30] && m_en) n_dis = 1; if (dd) n_dis = 0;
    n_nak = m_nak; if (we && wd[26]) n_nak = 0; if (we && wd[27]) n_nak = 1; if (su) n_nak = 1;
    n_st = m_stall; if (we && wd[21]) n_st = 1; if (su) n_st = 0;
    @(negedge clk);
    m_en = n_en; m_dis = n_dis; m_nak = n_nak; m_stall = n_st; m_di = xd; m_ri = dd;
    wr_en = 0; setup_rx = 0; xfer_done = 0; dis_done = 0;
    chk("R2/R3/R7/R9 rd", rd_data, exp_rd());
    chk("R2 ep_enabled", {31'b0, ep_enabled}, {31'b0, m_en});
    chk("R4 done_irq", {31'b0, done_irq}, {31'b0, m_di});
    chk("R4 dis_irq", {31'b0, dis_irq}, {31'b0, m_ri});
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd", rd_data, 32'h0);
    chk("R1 hs", {30'b0, hs_sel}, 32'h1);
    chk("R1 irq", {30'b0, done_irq, dis_irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // R3 disable ignored while not enabled
    step(1, 32'h4000_0000, 0, 0, 0, 0, 0);
    // R2 enable, R8 data allowed
    step(1, 32'h8000_0000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    // R3 disable accepted then dis_done, R4 pulse
    step(1, 32'h4000_0000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R2 event beats same-cycle set write
    step(1, 32'h8000_0000, 0, 1, 0, 0, 0);
    step(1, 32'h8000_0000, 0, 0, 0, 0, 0);
    step(1, 32'hC000_0000, 0, 0, 1, 0, 0);
    // R5 set-NAK and clear-NAK together: set wins
    step(1, 32'h8C00_0000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h0400_0000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R7 stall, R8 stall over all NAK sources
    step(1, 32'h0820_0000, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    // R6 setup beats clear-NAK and set-stall
    step(1, 32'h0420_0000, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h0400_0000, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd = $urandom;
      step(($urandom % 3) == 0, wd, ($urandom % 16) == 0, ($urandom % 12) == 0,
           ($urandom % 12) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule